// File: doc/BRIEF.md
# Two-Level VF Local-Memory Translation Walker

This block turns a local-memory offset issued by a virtual function into the matching offset in the physical function's local memory. A request supplies a VF number and a VF offset. The block reads one 32-bit directory entry, picked by the VF number, from a table whose base address comes from the `dir_base` input. That entry points to a leaf table, stored in 64 KB units. The block then reads one 32-bit leaf entry, picked by bits above bit 21 of the offset. The leaf entry names a 2 MB target page. The low 21 offset bits pass through unchanged.

Only one walk runs at a time. The block uses a single read-only memory port: the request side is a valid/ready pair, and read data returns with a valid/ready pair after any number of cycles. Malformed requests never touch memory. A walk that meets an absent entry at either level ends with a fault code that says which level failed.

Top module: `vf_xlate_walker`

## Requirements
- R1: After reset, and after any cycle in which `rst` is high, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The first memory read of a walk uses address `dir_base + 4*vfid`, taken modulo 2^HAW.
- R3: The second memory read of a walk uses address `ptr*65536 + 4*((offset >> 21) mod 2^(HAW-21))`. Here `ptr` is the directory entry bits [HAW-13:4].
- R4: A walk that completes returns fault code 0 and `rsp_addr = page*2^21 + offset[20:0]`. Here `page` is the leaf entry bits [HAW-17:5].
- R5: A request with vfid 0, a vfid of 64 or more, or an offset of 2^HAW or above is answered with fault code 1 and makes no memory read.
- R6: A directory entry with bit 0 clear ends the walk after exactly one read, with fault code 2.
- R7: A leaf entry with bit 0 clear ends the walk after exactly two reads, with fault code 3.
- R8: Entry bits outside the valid bit and the pointer or page field have no effect on the translation.
- R9: From the acceptance of a request until its response is taken, `req_ready` stays 0, and a request presented in that time is ignored.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_addr` and `rsp_fault` hold their values.
- R11: `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen. No memory request is issued while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base | input | HAW | Byte address of the directory table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_vfid | input | VFID_W | Requesting VF number |
| req_offset | input | OFF_W | VF local-memory offset |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | HAW | Translated offset (0 on fault) |
| rsp_fault | output | 2 | 0 ok, 1 bad request, 2 directory absent, 3 leaf absent |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | HAW | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Block waits for read data |
| mem_rsp_data | input | 32 | Fetched table entry |

## Verification
On every cycle, the assertions check the handshake rules. They cover the reset state, the response and memory-request hold while stalled, `req_ready` staying low while busy, no memory request while a response is pending, and the immediate memory-free fault for malformed requests. Only the bench's scenarios can show the values. Those are the address arithmetic at both levels, the translated offset, the read count for each fault kind, and the fact that reserved entry bits and requests made while busy leave the result unchanged. The bench drives these against a memory model with varying latency.

// File: rtl/vfx_pkg.sv
package vfx_pkg;

    localparam int ENTRY_W        = 32;
    localparam int PAGE_SHIFT     = 21;   // 2 MB leaf pages
    localparam int TABLE_SHIFT    = 16;   // 64 KB leaf-table granularity
    localparam int ENTRY_SZ_LOG2  = 2;    // 4-byte entries
    localparam int DIR_PTR_LSB    = 4;
    localparam int LEAF_PAGE_LSB  = 5;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_REQ  = 2'd1,
        FLT_DIR  = 2'd2,
        FLT_LEAF = 2'd3
    } vfx_fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_WT_DIR,
        ST_RD_LEAF,
        ST_WT_LEAF,
        ST_RESP
    } vfx_state_e;

    function automatic logic entry_present(input logic [ENTRY_W-1:0] e);
        return e[0];
    endfunction

endpackage

// File: rtl/vfx_entry_field.sv
module vfx_entry_field
    import vfx_pkg::*;
#(
    parameter int FIELD_LSB = 4,
    parameter int FIELD_W   = 21
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic [FIELD_W-1:0] field,
    output logic               present
);
    // reserved bits are deliberately dropped
    logic rsvd_unused;
    assign rsvd_unused = ^entry;

    assign field   = entry[FIELD_LSB +: FIELD_W];
    assign present = entry_present(entry);
endmodule

// File: rtl/vfx_req_screen.sv
module vfx_req_screen #(
    parameter int HAW         = 37,
    parameter int VFID_W      = 8,
    parameter int OFF_W       = 48,
    parameter int DIR_ENTRIES = 64
) (
    input  logic [VFID_W-1:0] vfid,
    input  logic [OFF_W-1:0]  offset,
    output logic              reject
);
    logic id_bad;
    logic off_bad;

    assign id_bad = (vfid == '0) ||
                    ({1'b0, vfid} >= (VFID_W+1)'(DIR_ENTRIES));

    generate
        if (OFF_W > HAW) begin : g_range
            assign off_bad = (offset[OFF_W-1:HAW] != '0);
        end else begin : g_fit
            assign off_bad = 1'b0;
        end
    endgenerate

    assign reject = id_bad || off_bad;
endmodule

// File: rtl/vf_xlate_walker.sv
module vf_xlate_walker
    import vfx_pkg::*;
#(
    parameter int HAW         = 37,
    parameter int VFID_W      = 8,
    parameter int OFF_W       = 48,
    parameter int DIR_ENTRIES = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HAW-1:0]     dir_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VFID_W-1:0]  req_vfid,
    input  logic [OFF_W-1:0]   req_offset,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [HAW-1:0]     rsp_addr,
    output logic [1:0]         rsp_fault,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [HAW-1:0]     mem_req_addr,
    input  logic               mem_rsp_valid,
    output logic               mem_rsp_ready,
    input  logic [ENTRY_W-1:0] mem_rsp_data
);
    localparam int PTR_W  = HAW - TABLE_SHIFT;
    localparam int PAGE_W = HAW - PAGE_SHIFT;
    localparam int IDX_W  = HAW - PAGE_SHIFT;

    vfx_state_e           state_q;
    logic [VFID_W-1:0]    vfid_q;
    logic [HAW-1:0]       off_q;
    logic [PTR_W-1:0]     ptr_q;
    logic [HAW-1:0]       addr_q;
    vfx_fault_e           fault_q;

    logic                 reject;
    logic [PTR_W-1:0]     dir_ptr;
    logic                 dir_ok;
    logic [PAGE_W-1:0]    leaf_page;
    logic                 leaf_ok;
    logic [IDX_W-1:0]     leaf_idx;
    logic [HAW-1:0]       dir_addr;
    logic [HAW-1:0]       leaf_addr;

    vfx_req_screen #(
        .HAW(HAW), .VFID_W(VFID_W), .OFF_W(OFF_W), .DIR_ENTRIES(DIR_ENTRIES)
    ) i_screen (
        .vfid   (req_vfid),
        .offset (req_offset),
        .reject (reject)
    );

    vfx_entry_field #(.FIELD_LSB(DIR_PTR_LSB), .FIELD_W(PTR_W)) i_dir_fld (
        .entry   (mem_rsp_data),
        .field   (dir_ptr),
        .present (dir_ok)
    );

    vfx_entry_field #(.FIELD_LSB(LEAF_PAGE_LSB), .FIELD_W(PAGE_W)) i_leaf_fld (
        .entry   (mem_rsp_data),
        .field   (leaf_page),
        .present (leaf_ok)
    );

    assign leaf_idx  = off_q[HAW-1:PAGE_SHIFT];
    assign dir_addr  = dir_base + HAW'({vfid_q, {ENTRY_SZ_LOG2{1'b0}}});
    assign leaf_addr = {ptr_q, {TABLE_SHIFT{1'b0}}}
                     + HAW'({leaf_idx, {ENTRY_SZ_LOG2{1'b0}}});

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_RD_DIR) || (state_q == ST_RD_LEAF);
    assign mem_req_addr  = (state_q == ST_RD_DIR) ? dir_addr : leaf_addr;
    assign mem_rsp_ready = (state_q == ST_WT_DIR) || (state_q == ST_WT_LEAF);
    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_addr      = addr_q;
    assign rsp_fault     = fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vfid_q  <= '0;
            off_q   <= '0;
            ptr_q   <= '0;
            addr_q  <= '0;
            fault_q <= FLT_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vfid_q <= req_vfid;
                        off_q  <= req_offset[HAW-1:0];
                        if (reject) begin
                            addr_q  <= '0;
                            fault_q <= FLT_REQ;
                            state_q <= ST_RESP;
                        end else begin
                            state_q <= ST_RD_DIR;
                        end
                    end
                end
                ST_RD_DIR: begin
                    if (mem_req_ready) state_q <= ST_WT_DIR;
                end
                ST_WT_DIR: begin
                    if (mem_rsp_valid) begin
                        if (!dir_ok) begin
                            addr_q  <= '0;
                            fault_q <= FLT_DIR;
                            state_q <= ST_RESP;
                        end else begin
                            ptr_q   <= dir_ptr;
                            state_q <= ST_RD_LEAF;
                        end
                    end
                end
                ST_RD_LEAF: begin
                    if (mem_req_ready) state_q <= ST_WT_LEAF;
                end
                ST_WT_LEAF: begin
                    if (mem_rsp_valid) begin
                        if (!leaf_ok) begin
                            addr_q  <= '0;
                            fault_q <= FLT_LEAF;
                        end else begin
                            addr_q  <= {leaf_page, off_q[PAGE_SHIFT-1:0]};
                            fault_q <= FLT_NONE;
                        end
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vfx_walker_chk.sv
module vfx_walker_chk #(
    parameter int HAW         = 37,
    parameter int VFID_W      = 8,
    parameter int OFF_W       = 48,
    parameter int DIR_ENTRIES = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VFID_W-1:0] req_vfid,
    input logic [OFF_W-1:0]  req_offset,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [HAW-1:0]    rsp_addr,
    input logic [1:0]        rsp_fault,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [HAW-1:0]    mem_req_addr
);
    logic bad_req;
    assign bad_req = (req_vfid == '0)
                  || ({1'b0, req_vfid} >= (VFID_W+1)'(DIR_ENTRIES))
                  || ((req_offset >> HAW) != '0);

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid && !mem_req_valid)); // R1

    AST_BAD_REQ_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && bad_req) |=>
            (rsp_valid && rsp_fault == 2'd1 && !mem_req_valid)); // R5

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || mem_req_valid) |-> !req_ready); // R9

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault))); // R10

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr))); // R11

    AST_NO_READ_IN_RESP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_req_valid); // R11
endmodule

bind vf_xlate_walker vfx_walker_chk #(
    .HAW(HAW), .VFID_W(VFID_W), .OFF_W(OFF_W), .DIR_ENTRIES(DIR_ENTRIES)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vfid      (req_vfid),
    .req_offset    (req_offset),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_addr      (rsp_addr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/test_vf_xlate_walker.sv
module test_vf_xlate_walker;
    localparam int CLK_PERIOD = 10;
    localparam int HAW    = 37;
    localparam int VFID_W = 8;
    localparam int OFF_W  = 48;
    localparam logic [HAW-1:0] DIRB = 37'h0_4000_0100;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [VFID_W-1:0] req_vfid = '0;
    logic [OFF_W-1:0]  req_offset = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [HAW-1:0]    rsp_addr;
    logic [1:0]        rsp_fault;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [HAW-1:0]    mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic              mem_rsp_ready;
    logic [31:0]       mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    logic [HAW-1:0] rd_log [64];
    logic [31:0]    dir_mem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    vf_xlate_walker #(.HAW(HAW), .VFID_W(VFID_W), .OFF_W(OFF_W), .DIR_ENTRIES(64))
    i_vf_xlate_walker (
        .clk(clk), .rst(rst), .dir_base(DIRB),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vfid(req_vfid), .req_offset(req_offset),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
    );

    // leaf content: page = addr[17:2] ^ 5A3C, absent when addr[17:2]==0777,
    // reserved bits filled with address-dependent junk
    function automatic logic [31:0] leaf_word(input logic [HAW-1:0] a);
        logic [15:0] pg;
        pg = a[17:2] ^ 16'h5A3C;
        return {a[12:2], pg, a[5:2], (a[17:2] != 16'h0777)};
    endfunction

    function automatic logic [31:0] mem_word(input logic [HAW-1:0] a);
        if (a >= DIRB && a < DIRB + 37'd256)
            return dir_mem[6'((a - DIRB) >> 2)];
        return leaf_word(a);
    endfunction

    // memory model: one stall cycle before accept, then 0..3 cycles latency
    bit pend = 0;
    int lat_cnt = 0;
    logic [HAW-1:0] cap = '0;
    always @(negedge clk) begin
        if (rst) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            pend = 0;
        end else begin
            if (mem_rsp_valid) mem_rsp_valid = 1'b0;
            if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                pend = 1;
                lat_cnt = rd_cnt % 4;
            end else if (pend) begin
                if (lat_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(cap);
                    pend = 0;
                end else begin
                    lat_cnt--;
                end
            end else if (mem_req_valid) begin
                mem_req_ready = 1'b1;
                cap = mem_req_addr;
                rd_log[rd_cnt % 64] = cap;
                rd_cnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic walk(input logic [7:0] v, input logic [47:0] off,
                        output logic [1:0] code, output logic [HAW-1:0] xa,
                        output int nrd, output int first);
        int n;
        first = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_vfid = v; req_offset = off;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 500) begin @(negedge clk); n++; end
        code = rsp_fault; xa = rsp_addr;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        nrd = rd_cnt - first;
    endtask

    function automatic logic [HAW-1:0] exp_leaf(input logic [7:0] v, input logic [47:0] off);
        logic [63:0] p, ix;
        p  = 64'(dir_mem[6'(v)][24:4]);
        ix = (64'(off) >> 21) & 64'hFFFF;
        return HAW'((p << 16) + (ix << 2));
    endfunction

    typedef struct packed {
        logic [7:0]  vfid;
        logic [47:0] off;
        logic [1:0]  code;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{8'd1,   48'h0,             2'd0},
        '{8'd2,   48'h0_0123_4567,   2'd0},
        '{8'd63,  48'h1F_FFFF_FFFF,  2'd0},
        '{8'd0,   48'h0,             2'd1},
        '{8'd64,  48'h0,             2'd1},
        '{8'd200, 48'h10,            2'd1},
        '{8'd3,   48'h20_0000_0000,  2'd1},
        '{8'd5,   48'h40_0000,       2'd2},
        '{8'd4,   48'h18_EEE1_2345,  2'd3},
        '{8'd9,   48'h0_0A5A_5A5A,   2'd0},
        '{8'd10,  48'h0_0A5A_5A5A,   2'd0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] code;
        logic [HAW-1:0] xa, xa9;
        logic [HAW-1:0] ea;
        int nrd, first;
        logic [HAW-1:0] held_a;
        logic [1:0] held_f;

        for (int v = 0; v < 64; v++) begin
            logic [20:0] p;
            p = 21'(v * 3 + 1);
            dir_mem[v] = {7'h55, p, 3'b101, (v != 5)};
        end
        // same pointer, reserved bits all clear vs all set (R8)
        dir_mem[9]  = {7'h00, 21'd28, 3'b000, 1'b1};
        dir_mem[10] = {7'h7F, 21'd28, 3'b111, 1'b1};
        xa9 = '0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);

        foreach (VECS[i]) begin
            int exp_rd;
            walk(VECS[i].vfid, VECS[i].off, code, xa, nrd, first);
            exp_rd = (VECS[i].code == 2'd0) ? 2 : (VECS[i].code == 2'd1) ? 0 :
                     (VECS[i].code == 2'd2) ? 1 : 2;
            case (VECS[i].code)
                2'd1: chk("R5 fault code", 64'(code), 64'd1);
                2'd2: chk("R6 fault code", 64'(code), 64'd2);
                2'd3: chk("R7 fault code", 64'(code), 64'd3);
                default: chk("R4 fault code", 64'(code), 64'd0);
            endcase
            chk("R5 R6 R7 read count", 64'(nrd), 64'(exp_rd));
            if (nrd >= 1)
                chk("R2 directory address", 64'(rd_log[first % 64]),
                    64'(DIRB + HAW'(VECS[i].vfid) * 37'd4));
            if (nrd == 2 && exp_rd == 2)
                chk("R3 leaf address", 64'(rd_log[(first + 1) % 64]),
                    64'(exp_leaf(VECS[i].vfid, VECS[i].off)));
            if (VECS[i].code == 2'd0) begin
                ea = exp_leaf(VECS[i].vfid, VECS[i].off);
                chk("R4 translated", 64'(xa),
                    (64'(ea[17:2] ^ 16'h5A3C) << 21) | 64'(VECS[i].off[20:0]));
            end
            if (VECS[i].vfid == 8'd9)  xa9 = xa;
            if (VECS[i].vfid == 8'd10) chk("R8 reserved bits ignored", 64'(xa), 64'(xa9));
        end

        // R9 R10: hold response, offer another request while busy
        @(negedge clk);
        req_valid = 1'b1; req_vfid = 8'd2; req_offset = 48'h0_0080_0001;
        @(negedge clk);
        req_vfid = 8'd7; req_offset = 48'h0_0000_0002;
        while (!rsp_valid) @(negedge clk);
        held_a = rsp_addr; held_f = rsp_fault;
        first = rd_cnt;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R9 req_ready low while busy", 64'(req_ready), 64'd0);
            chk("R10 rsp held", {25'd0, rsp_valid, rsp_fault, rsp_addr},
                {25'd0, 1'b1, held_f, held_a});
        end
        req_valid = 1'b0;
        ea = exp_leaf(8'd2, 48'h0_0080_0001);
        chk("R9 first request kept", 64'(held_a),
            (64'(ea[17:2] ^ 16'h5A3C) << 21) | 64'h1);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        repeat (6) @(negedge clk);
        chk("R9 busy request dropped: no walk", 64'(rd_cnt - first), 64'd0);
        chk("R9 busy request dropped: no response", 64'(rsp_valid), 64'd0);

        // R1: reset in the middle of a walk
        @(negedge clk);
        req_valid = 1'b1; req_vfid = 8'd1; req_offset = 48'h0;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-walk reset req_ready", 64'(req_ready), 64'd1);
        chk("R1 mid-walk reset idle", {62'd0, rsp_valid, mem_req_valid}, 64'd0);

        // R6 after reset the block walks normally again
        walk(8'd5, 48'h0, code, xa, nrd, first);
        chk("R6 fault after reset", 64'(code), 64'd2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule